// File: doc/BRIEF.md
# Switchable-Width Byte-Lane SRAM Core

This block is a synchronous on-chip memory whose single port can be used in two ways. In word mode it stores and returns 16-bit words, and two active-low lane strobes choose which byte of each word takes part in the access. In byte mode the same storage is seen as twice as many 8-bit locations. A separate byte-address input then acts as the lowest address bit and picks the half of the stored word. All byte traffic uses the low data lane only.

Two chip enables of opposite polarity gate every access. Writes are committed on the rising clock edge on which all write conditions hold. A read returns its data from a register one clock after it is requested. The data port is split into an input bus, an output bus and a per-lane output enable, so the tristate buffer can be placed outside the block. The stored range is set by a parameter. An address outside that range is decoded as empty space.

Top module: `flex_width_sram`

## Requirements
- R1: An access takes place only when `enaN` is 0 and `enaHi` is 1. Otherwise nothing is written, and after the next edge `dataOe` is 2'b00 and `dataOut` is 0.
- R2: In word mode, a read (`weN`=1, `oeN`=0) sets `dataOe[0]` to the inverse of `lbN` and `dataOe[1]` to the inverse of `ubN`, one clock after the request. Each enabled lane carries its stored byte: lane 0 is bits 7:0 and lane 1 is bits 15:8. A disabled lane outputs zero.
- R3: In word mode, a write (`weN`=0) stores `dataIn[7:0]` into the low byte when `lbN`=0 and stores `dataIn[15:8]` into the high byte when `ubN`=0. A byte whose strobe is 1 is left unchanged.
- R4: In word mode, `lbN`=`ubN`=1 acts as a deselect. The access writes nothing and drives nothing.
- R5: In byte mode (`wordMode`=0), a write stores `dataIn[7:0]` into the low half of the addressed word when `byteAddr`=0, or into the high half when `byteAddr`=1.
- R6: In byte mode, a read returns the selected half on `dataOut[7:0]` with `dataOe`=2'b01 and `dataOut[15:8]`=0. The lane strobes have no effect in this mode.
- R7: In word mode, `byteAddr` has no effect.
- R8: A read drives data only when `weN`=1 and `oeN`=0. With `oeN`=1, `dataOe` is 2'b00.
- R9: A write takes place whenever `weN`=0, whatever the value of `oeN`. A write cycle never drives the outputs.
- R10: While `rst_n`=0, `dataOe`=2'b00 and `dataOut`=0. Reset takes effect at once, without waiting for a clock edge.
- R11: Only addresses below 2**STORE_W words are populated. A write above that range is dropped. A read above that range returns zero data on the enabled lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| addr | input | ADDR_W | Word address |
| byteAddr | input | 1 | Lowest address bit in byte mode (0 = low half) |
| wordMode | input | 1 | 1 = 16-bit word organisation, 0 = byte organisation |
| enaN | input | 1 | Chip enable, active low |
| enaHi | input | 1 | Chip enable, active high |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| lbN | input | 1 | Low-lane strobe, active low (word mode) |
| ubN | input | 1 | High-lane strobe, active low (word mode) |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Registered read data |
| dataOe | output | 2 | Per-lane output enable (bit 0 = bits 7:0) |

## Verification
A write lands on the rising edge at which it is presented, so it can only be seen through a later read. A read request presented before edge k shows its data and lane enables just after edge k and holds them until edge k+1. The bench therefore drives each vector on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. Reset is the one exception: it acts without a clock, so it is checked a few nanoseconds after `rst_n` falls, midway between edges.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic             byteMode;
    logic             byteSel;
    logic             hit;
    logic [LANES-1:0] wrLane;
    logic [LANES-1:0] rdLane;
  } laneCtrl_t;
endpackage

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int STORE_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteAddr,
  input  logic              wordMode,
  input  logic              enaN,
  input  logic              enaHi,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              ubN,
  output laneCtrl_t         strb
);
  logic             chipOn;
  logic             lanesOn;
  logic             active;
  logic             wrOn;
  logic             rdOn;
  logic             inRange;
  logic [LANES-1:0] wordLanes;
  logic [LANES-1:0] byteLanes;

  always_comb begin
    chipOn    = !enaN && enaHi;
    lanesOn   = wordMode ? !(lbN && ubN) : 1'b1;
    active    = chipOn && lanesOn;
    wrOn      = active && !weN;
    rdOn      = active && weN && !oeN;
    inRange   = ((addr >> STORE_W) == '0);
    wordLanes = {!ubN, !lbN};
    byteLanes = byteAddr ? 2'b10 : 2'b01;

    strb.byteMode = !wordMode;
    strb.byteSel  = byteAddr;
    strb.hit      = inRange;
    strb.wrLane   = (wrOn && inRange) ? (wordMode ? wordLanes : byteLanes) : '0;
    strb.rdLane   = rdOn ? (wordMode ? wordLanes : 2'b01) : '0;
  end
endmodule

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int STORE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  laneCtrl_t          strb,
  input  logic [STORE_W-1:0] index,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [DATA_W-1:0]  dataOut,
  output logic [LANES-1:0]   dataOe
);
  localparam int DEPTH = 1 << STORE_W;

  logic [DATA_W-1:0] rdWord;
  logic [LANE_W-1:0] lowPick;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] wrByte;

    assign wrByte = strb.byteMode ? dataIn[LANE_W-1:0] : dataIn[lane*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (strb.wrLane[lane]) bank[index] <= wrByte;
    end

    assign rdWord[lane*LANE_W +: LANE_W] = strb.hit ? bank[index] : '0;
  end

  assign lowPick = (strb.byteMode && strb.byteSel) ? rdWord[DATA_W-1:LANE_W]
                                                   : rdWord[LANE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut <= '0;
      dataOe  <= '0;
    end else begin
      dataOe                  <= strb.rdLane;
      dataOut[LANE_W-1:0]     <= strb.rdLane[0] ? lowPick : '0;
      dataOut[DATA_W-1:LANE_W] <= strb.rdLane[1] ? rdWord[DATA_W-1:LANE_W] : '0;
    end
  end
endmodule

// File: rtl/flex_width_sram.sv
module flex_width_sram
  import fws_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int STORE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteAddr,
  input  logic              wordMode,
  input  logic              enaN,
  input  logic              enaHi,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        dataOe
);
  laneCtrl_t strb;

  fws_ctrl #(.ADDR_W(ADDR_W), .STORE_W(STORE_W)) u_ctrl (
    .addr(addr), .byteAddr(byteAddr), .wordMode(wordMode),
    .enaN(enaN), .enaHi(enaHi), .weN(weN), .oeN(oeN),
    .lbN(lbN), .ubN(ubN), .strb(strb)
  );

  fws_datapath #(.STORE_W(STORE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .index(addr[STORE_W-1:0]), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/fws_checker.sv
module fws_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wordMode,
  input logic        enaN,
  input logic        enaHi,
  input logic        weN,
  input logic        oeN,
  input logic        lbN,
  input logic        ubN,
  input logic [15:0] dataOut,
  input logic [1:0]  dataOe
);
  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!enaN && enaHi) |=> (dataOe == 2'b00 && dataOut == 16'h0));

  assert_word_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wordMode && !enaN && enaHi && weN && !oeN && !(lbN && ubN))
      |=> dataOe == {!$past(ubN), !$past(lbN)});

  assert_no_strobe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wordMode && lbN && ubN) |=> dataOe == 2'b00);

  assert_byte_low_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wordMode && !enaN && enaHi && weN && !oeN)
      |=> (dataOe == 2'b01 && dataOut[15:8] == 8'h0));

  assert_oe_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oeN && weN) |=> dataOe == 2'b00);

  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !weN |=> dataOe == 2'b00);
endmodule

bind flex_width_sram fws_checker chk (
  .clk(clk), .rst_n(rst_n), .wordMode(wordMode), .enaN(enaN), .enaHi(enaHi),
  .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/tb_flex_width_sram.sv
module tb_flex_width_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        byteAddr = 1'b0;
  logic        wordMode = 1'b1;
  logic        enaN = 1'b1;
  logic        enaHi = 1'b0;
  logic        weN = 1'b1;
  logic        oeN = 1'b1;
  logic        lbN = 1'b1;
  logic        ubN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  dataOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flex_width_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .byteAddr(byteAddr), .wordMode(wordMode),
    .enaN(enaN), .enaHi(enaHi), .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  typedef struct packed {
    logic        wm, ba, eN, eH, we, oe, lb, ub;
    logic [19:0] ad;
    logic [15:0] din;
    logic [1:0]  eOe;
    logic [15:0] eOut;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,1,0,1,0,0,20'h5,  16'hA1B2,2'b00,16'h0000,4'd3},  // R3 full write
    '{1,0,0,1,1,0,0,0,20'h5,  16'h0000,2'b11,16'hA1B2,4'd2},  // R2 full read
    '{1,0,0,1,0,1,0,1,20'h6,  16'h1234,2'b00,16'h0000,4'd3},  // R3 low only
    '{1,0,0,1,0,1,1,0,20'h6,  16'h5678,2'b00,16'h0000,4'd3},  // R3 high only
    '{1,0,0,1,1,0,0,0,20'h6,  16'h0000,2'b11,16'h5634,4'd3},  // R3 merged
    '{1,0,0,1,1,0,0,1,20'h6,  16'h0000,2'b01,16'h0034,4'd2},  // R2 low lane
    '{1,0,0,1,1,0,1,0,20'h6,  16'h0000,2'b10,16'h5600,4'd2},  // R2 high lane
    '{1,0,0,1,0,1,0,0,20'h7,  16'h0F0F,2'b00,16'h0000,4'd3},
    '{1,0,0,1,0,1,1,1,20'h7,  16'hFFFF,2'b00,16'h0000,4'd4},  // R4 write w/o strobes
    '{1,0,0,1,1,0,1,1,20'h7,  16'h0000,2'b00,16'h0000,4'd4},  // R4 read w/o strobes
    '{1,0,0,1,1,0,0,0,20'h7,  16'h0000,2'b11,16'h0F0F,4'd4},
    '{1,0,1,1,0,1,0,0,20'h5,  16'h0000,2'b00,16'h0000,4'd1},  // R1 enaN high
    '{1,0,0,0,0,1,0,0,20'h5,  16'h0000,2'b00,16'h0000,4'd1},  // R1 enaHi low
    '{1,0,1,1,1,0,0,0,20'h5,  16'h0000,2'b00,16'h0000,4'd1},
    '{1,0,0,1,1,0,0,0,20'h5,  16'h0000,2'b11,16'hA1B2,4'd1},
    '{0,0,0,1,0,1,1,1,20'h9,  16'h77C3,2'b00,16'h0000,4'd5},  // R5 low half
    '{0,1,0,1,0,1,1,1,20'h9,  16'h005A,2'b00,16'h0000,4'd5},  // R5 high half
    '{1,0,0,1,1,0,0,0,20'h9,  16'h0000,2'b11,16'h5AC3,4'd5},
    '{0,1,0,1,1,0,1,1,20'h9,  16'h0000,2'b01,16'h005A,4'd6},  // R6 strobes ignored
    '{0,0,0,1,1,0,0,0,20'h9,  16'h0000,2'b01,16'h00C3,4'd6},
    '{1,1,0,1,0,1,0,0,20'hA,  16'hBEEF,2'b00,16'h0000,4'd7},  // R7
    '{1,0,0,1,1,0,0,0,20'hA,  16'h0000,2'b11,16'hBEEF,4'd7},
    '{1,0,0,1,1,1,0,0,20'hA,  16'h0000,2'b00,16'h0000,4'd8},  // R8
    '{1,0,0,1,0,0,0,0,20'hB,  16'h4242,2'b00,16'h0000,4'd9},  // R9 write with oeN low
    '{1,0,0,1,1,0,0,0,20'hB,  16'h0000,2'b11,16'h4242,4'd9},
    '{1,0,0,1,0,1,0,0,20'h3,  16'h1111,2'b00,16'h0000,4'd11}, // R11
    '{1,0,0,1,0,1,0,0,20'h103,16'h7E7E,2'b00,16'h0000,4'd11},
    '{1,0,0,1,1,0,0,0,20'h3,  16'h0000,2'b11,16'h1111,4'd11},
    '{1,0,0,1,1,0,0,0,20'h103,16'h0000,2'b11,16'h0000,4'd11}
  };

  task automatic check(input int req, input logic [1:0] eOe, input logic [15:0] eOut);
    nChecks++;
    if (dataOe !== eOe || dataOut !== eOut) begin
      nFails++;
      $display("FAIL R%0d: oe=%b out=%h expected oe=%b out=%h", req, dataOe, dataOut, eOe, eOut);
    end
  endtask

  task automatic apply(input vec_t v);
    wordMode = v.wm; byteAddr = v.ba; enaN = v.eN; enaHi = v.eH;
    weN = v.we; oeN = v.oe; lbN = v.lb; ubN = v.ub; addr = v.ad; dataIn = v.din;
  endtask

  task automatic idle();
    enaN = 1'b1; enaHi = 1'b0; weN = 1'b1; oeN = 1'b1; lbN = 1'b1; ubN = 1'b1;
  endtask

  initial begin
    #3;
    check(10, 2'b00, 16'h0000);  // R10 during reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(10, 2'b00, 16'h0000);  // R10 after release
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      check(int'(VECS[i].req), VECS[i].eOe, VECS[i].eOut);
    end
    // R10: reset clears outputs asynchronously while a read is being shown
    apply(VECS[1]);
    @(posedge clk);
    @(negedge clk);
    check(2, 2'b11, 16'hA1B2);
    idle();
    #2 rst_n = 1'b0;
    #3 check(10, 2'b00, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    apply(VECS[1]);
    @(posedge clk);
    @(negedge clk);
    check(10, 2'b11, 16'hA1B2);
    idle();
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL R1: watchdog expired, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule